// File: doc/BRIEF.md
# Burst DMA Channel with Non-Maskable Abort

A single memory-to-memory DMA channel that copies a programmed number of byte or word units from a source address to a destination address over a bus it shares with the CPU. Each unit is one read cycle followed by one write cycle. Before it touches the bus, the channel asks for the bus with a request/grant handshake. In burst mode it keeps the bus from the first unit to the last. In cycle-steal mode it hands the bus back after every unit and asks for it again for the next one.

Software programs the source address, the destination address, the unit count and a control word through a small register port, then sets two enables. Both the channel enable and the master enable must be set for the channel to move data. The channel clears the channel enable itself when the count runs out, and it raises a done flag at that point. In burst mode, a non-maskable interrupt clears the master enable. The channel then finishes the unit it has started, releases the bus, and holds its addresses and remaining count. Setting the master enable again makes it continue from where it stopped.

Top module: `dma_burst_channel`

## Requirements
- R1: The channel raises `bus_req` only when the channel enable (control bit 0) and the master enable (control bit 1) are both 1 and the remaining count is nonzero. Otherwise `bus_req` stays low.
- R2: Once raised, `bus_req` stays high until `bus_gnt` is seen. `bus_rd` is never asserted while `bus_gnt` is low.
- R3: A unit's read and write are never split. The cycle after a read completes (`bus_rd` and `bus_rdy`) carries `bus_wr` with `bus_req` still high. `bus_req` never falls in the cycle after a read cycle, and `bus_rd` and `bus_wr` are never high together.
- R4: In burst mode (control bit 2 = 1), `bus_req` stays high from the first read to the last write of the programmed count. It falls exactly once per run.
- R5: In cycle-steal mode (control bit 2 = 0), `bus_req` is low in the cycle after every completed write. It falls once per unit.
- R6: Word units (control bit 3 = 1) step an incrementing address by 2, and byte units step it by 1. The source address increments when control bit 4 is 1 and the destination address when control bit 5 is 1; otherwise each stays fixed. `bus_word` shows the unit size.
- R7: The count decrements once per completed unit. When it reaches zero, the channel clears the channel enable, sets `done` (control bit 6 on readback) and releases the bus. Any write to the control register clears `done`.
- R8: A `nmi` cycle while control bit 2 is 1 clears the master enable. The unit in progress still completes, and then `bus_req` falls with no further unit started.
- R9: `nmi` has no effect while control bit 2 is 0. The master enable stays 1 and all units complete.
- R10: After an abort, the source address, the destination address and the count read back at the values the next unit needs. Setting the master enable again completes the remaining units at the continuing addresses.
- R11: A unit writes the data its read returned: all 16 bits for word units, and the low byte with zeroed upper bits for byte units.
- R12: Registers read back by `reg_sel`: 0 is the source address, 1 the destination address, 2 the count, and 3 the control word in bits [6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 source, 1 destination, 2 count, 3 control) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register readback for `reg_sel` |
| nmi | input | 1 | Non-maskable interrupt request, active high, one cycle or longer |
| bus_req | output | 1 | Bus request to the CPU arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_rd | output | 1 | Read cycle active |
| bus_wr | output | 1 | Write cycle active |
| bus_word | output | 1 | Unit size: 1 for word, 0 for byte |
| bus_addr | output | ADDR_W | Bus address (source during a read, destination during a write) |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid when `bus_rdy` is high during a read |
| bus_rdy | input | 1 | Completes the current read or write cycle |
| done | output | 1 | Terminal count reached |

## Verification
The properties assume an arbiter that keeps `bus_gnt` high for as long as `bus_req` stays high after granting, and drops it only when the request falls. They also assume that software writes the control register only while the channel is idle or stopped, and never in the same cycle as a terminal count. The bench's arbiter model grants after a programmable delay and holds the grant until the request falls. Its `bus_rdy` model adds 0 to 2 wait states per cycle. Every register write, including the one that re-arms the master enable, is made while `bus_req` is low.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic done;
        logic dst_inc;
        logic src_inc;
        logic word;
        logic burst;
        logic master_en;
        logic chan_en;
    } chan_cfg_t;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int unsigned CFG_W = $bits(chan_cfg_t);

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [5:0] cfg_wdata,
    input  logic       nmi,
    input  logic       tc,
    output chan_cfg_t  cfg_q,
    output logic       go
);

    chan_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.chan_en   = cfg_wdata[0];
            cfg_d.master_en = cfg_wdata[1];
            cfg_d.burst     = cfg_wdata[2];
            cfg_d.word      = cfg_wdata[3];
            cfg_d.src_inc   = cfg_wdata[4];
            cfg_d.dst_inc   = cfg_wdata[5];
            cfg_d.done      = 1'b0;
        end
        if (tc) begin
            cfg_d.chan_en = 1'b0;
            cfg_d.done    = 1'b1;
        end
        // abort applies to burst mode only; it outranks a same-cycle write
        if (nmi && cfg_q.burst) begin
            cfg_d.master_en = 1'b0;
        end
    end

    // enable seen by the sequencer already reflects an abort arriving this cycle
    assign go = cfg_q.chan_en && cfg_q.master_en && !(nmi && cfg_q.burst);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/dma_addr_count.sv
module dma_addr_count #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_src,
    input  logic              wr_dst,
    input  logic              wr_cnt,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              unit_done,
    input  logic              word,
    input  logic              src_inc,
    input  logic              dst_inc,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count,
    output logic              last,
    output logic              empty
);

    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
    } ac_state_t;

    ac_state_t ac_d, ac_q;
    logic [ADDR_W-1:0] step;

    assign step = word ? STEP_WORD : STEP_BYTE;

    always_comb begin
        ac_d = ac_q;
        if (wr_src) ac_d.src = wdata;
        if (wr_dst) ac_d.dst = wdata;
        if (wr_cnt) ac_d.cnt = wdata[CNT_W-1:0];
        if (unit_done) begin
            if (src_inc) ac_d.src = ac_q.src + step;
            if (dst_inc) ac_d.dst = ac_q.dst + step;
            ac_d.cnt = ac_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
        end else begin
            ac_q <= ac_d;
        end
    end

    assign src_addr = ac_q.src;
    assign dst_addr = ac_q.dst;
    assign count    = ac_q.cnt;
    assign last     = (ac_q.cnt == CNT_ONE);
    assign empty    = (ac_q.cnt == '0);

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
    import dma_chan_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              burst,
    input  logic              word,
    input  logic              empty,
    input  logic              last,
    input  logic              bus_gnt,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              unit_done,
    output logic              tc
);

    localparam int unsigned HI_W = DATA_W - 8;

    typedef struct packed {
        seq_state_e        st;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        bus_req   = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        unit_done = 1'b0;
        tc        = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (go && !empty) seq_d.st = ST_REQ;
            end
            ST_REQ: begin
                bus_req = 1'b1;
                // request is held until granted; enables are rechecked then
                if (bus_gnt) seq_d.st = go ? ST_READ : ST_IDLE;
            end
            ST_READ: begin
                bus_req = 1'b1;
                bus_rd  = 1'b1;
                if (bus_rdy) begin
                    seq_d.data = bus_rdata;
                    seq_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                bus_req = 1'b1;
                bus_wr  = 1'b1;
                if (bus_rdy) begin
                    unit_done = 1'b1;
                    if (last) begin
                        tc       = 1'b1;
                        seq_d.st = ST_IDLE;
                    end else if (burst && go) begin
                        seq_d.st = ST_READ;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, data: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_wdata = word ? seq_q.data : {{HI_W{1'b0}}, seq_q.data[7:0]};

endmodule

// File: rtl/dma_burst_channel.sv
module dma_burst_channel
    import dma_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              nmi,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rdy,
    output logic              done
);

    chan_cfg_t         cfg_q;
    logic              go;
    logic              tc;
    logic              unit_done;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [CNT_W-1:0]  count;
    logic              last;
    logic              empty;

    dma_cfg_regs i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (reg_wr && (reg_sel == SEL_CTRL)),
        .cfg_wdata (reg_wdata[5:0]),
        .nmi       (nmi),
        .tc        (tc),
        .cfg_q     (cfg_q),
        .go        (go)
    );

    dma_addr_count #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) i_ac (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_src    (reg_wr && (reg_sel == SEL_SRC)),
        .wr_dst    (reg_wr && (reg_sel == SEL_DST)),
        .wr_cnt    (reg_wr && (reg_sel == SEL_CNT)),
        .wdata     (reg_wdata),
        .unit_done (unit_done),
        .word      (cfg_q.word),
        .src_inc   (cfg_q.src_inc),
        .dst_inc   (cfg_q.dst_inc),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .count     (count),
        .last      (last),
        .empty     (empty)
    );

    dma_bus_seq #(
        .DATA_W (DATA_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .burst     (cfg_q.burst),
        .word      (cfg_q.word),
        .empty     (empty),
        .last      (last),
        .bus_gnt   (bus_gnt),
        .bus_rdy   (bus_rdy),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .unit_done (unit_done),
        .tc        (tc)
    );

    assign bus_addr = bus_wr ? dst_addr : src_addr;
    assign bus_word = cfg_q.word;
    assign done     = cfg_q.done;

    always_comb begin
        unique case (reg_sel)
            SEL_SRC:  reg_rdata = src_addr;
            SEL_DST:  reg_rdata = dst_addr;
            SEL_CNT:  reg_rdata = ADDR_W'(count);
            default:  reg_rdata = ADDR_W'(cfg_q);
        endcase
    end

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_rd,
    input logic bus_wr,
    input logic bus_rdy,
    input logic nmi,
    input logic burst,
    input logic master_en,
    input logic chan_en,
    input logic cfg_wr,
    input logic done
);

    assert_rd_needs_gnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> bus_gnt);

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    assert_unit_atomic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_rdy) |=> (bus_wr && bus_req));

    assert_no_release_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> !$past(bus_rd));

    assert_rd_wr_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_steal_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rdy && !burst) |=> !bus_req);

    assert_nmi_clears_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && burst) |=> !master_en);

    assert_nmi_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && !burst && master_en && !cfg_wr) |=> master_en);

    assert_done_clears_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !chan_en);

endmodule

bind dma_burst_channel dma_chan_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdy   (bus_rdy),
    .nmi       (nmi),
    .burst     (cfg_q.burst),
    .master_en (cfg_q.master_en),
    .chan_en   (cfg_q.chan_en),
    .cfg_wr    (reg_wr && (reg_sel == 2'd3)),
    .done      (done)
);

// File: tb/test_dma_burst_channel.sv
module test_dma_burst_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        nmi = 1'b0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_rd;
    logic        bus_wr;
    logic        bus_word;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_rdy;
    logic        done;

    always #4 clk = ~clk;

    dma_burst_channel i_dma_burst_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi(nmi),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .done(done)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // stimulus model settings
    int          wait_n = 0;
    int          gnt_dly = 0;
    int          wcnt = 0;
    int          gcnt = 0;
    logic [15:0] src0 = '0;
    logic [15:0] dst0 = '0;
    logic [15:0] sstep = '0;
    logic [15:0] dstep = '0;
    bit          cfg_word = 1'b0;
    int          k = 0;
    int          req_falls = 0;
    int          req_high = 0;
    bit          prev_req = 1'b0;

    function automatic logic [15:0] mem_val(input logic [15:0] a);
        return (a * 16'h0139) ^ 16'h5AC3;
    endfunction

    assign bus_rdata = mem_val(bus_addr);
    assign bus_rdy   = (wcnt >= wait_n);

    // arbiter: grant after gnt_dly cycles, hold until request falls
    always @(posedge clk) begin
        if (!bus_req) begin
            bus_gnt <= 1'b0;
            gcnt    <= 0;
        end else if (!bus_gnt) begin
            if (gcnt >= gnt_dly) bus_gnt <= 1'b1;
            else gcnt <= gcnt + 1;
        end
        if ((bus_rd || bus_wr) && !bus_rdy) wcnt <= wcnt + 1;
        else wcnt <= 0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bus monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_req && !bus_req) req_falls++;
            prev_req = bus_req;
            if (bus_req) req_high++;
            if (bus_rd && !bus_gnt) chk(1'b0, "R2", "read without grant", 32'(bus_rd), 32'd0);
            if (bus_rd && bus_rdy) begin
                chk(bus_addr == 16'(src0 + 16'(k) * sstep), "R6", "read address",
                    32'(bus_addr), 32'(16'(src0 + 16'(k) * sstep)));
                chk(bus_word == cfg_word, "R6", "unit size", 32'(bus_word), 32'(cfg_word));
            end
            if (bus_wr && bus_rdy) begin
                logic [15:0] ev;
                ev = mem_val(16'(src0 + 16'(k) * sstep));
                if (!cfg_word) ev = {8'h00, ev[7:0]};
                chk(bus_addr == 16'(dst0 + 16'(k) * dstep), "R6", "write address",
                    32'(bus_addr), 32'(16'(dst0 + 16'(k) * dstep)));
                chk(bus_wdata == ev, "R11", "write data", 32'(bus_wdata), 32'(ev));
                k++;
            end
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] val);
        @(posedge clk);
        #1;
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = val;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [15:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    function automatic logic [15:0] ctrl_word(input bit ce, input bit me, input bit b,
                                              input bit w, input bit si, input bit di);
        return {10'd0, di, si, w, b, me, ce};
    endfunction

    task automatic setup(input bit w, input bit si, input bit di, input logic [15:0] s,
                         input logic [15:0] d, input int cnt, input int wt, input int gd);
        cfg_word = w;
        src0     = s;
        dst0     = d;
        sstep    = si ? (w ? 16'd2 : 16'd1) : 16'd0;
        dstep    = di ? (w ? 16'd2 : 16'd1) : 16'd0;
        wait_n   = wt;
        gnt_dly  = gd;
        k        = 0;
        reg_write(2'd0, s);
        reg_write(2'd1, d);
        reg_write(2'd2, 16'(cnt));
        req_falls = 0;
        req_high  = 0;
    endtask

    task automatic wait_done;
        for (int i = 0; i < 400 && !done; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input bit w, input bit b, input bit si, input bit di,
                            input int cnt, input int wt, input int gd);
        logic [15:0] rv;
        setup(w, si, di, 16'h1200 + 16'(cnt * 16), 16'h8F00 + 16'(wt), cnt, wt, gd);
        reg_write(2'd3, ctrl_word(1, 1, b, w, si, di));
        wait_done();
        chk(done == 1'b1, "R7", "done set", 32'(done), 32'd1);
        chk(k == cnt, "R7", "units moved", 32'(k), 32'(cnt));
        if (b) chk(req_falls == 1, "R4", "burst releases once", 32'(req_falls), 32'd1);
        else chk(req_falls == cnt, "R5", "steal releases per unit", 32'(req_falls), 32'(cnt));
        chk(bus_req == 1'b0, "R7", "bus released at end", 32'(bus_req), 32'd0);
        reg_read(2'd2, rv);
        chk(rv == 16'd0, "R7", "count at zero", 32'(rv), 32'd0);
        reg_read(2'd0, rv);
        chk(rv == 16'(src0 + 16'(cnt) * sstep), "R6", "final source", 32'(rv),
            32'(16'(src0 + 16'(cnt) * sstep)));
        reg_read(2'd1, rv);
        chk(rv == 16'(dst0 + 16'(cnt) * dstep), "R6", "final destination", 32'(rv),
            32'(16'(dst0 + 16'(cnt) * dstep)));
        reg_read(2'd3, rv);
        chk(rv[0] == 1'b0, "R7", "channel enable cleared", 32'(rv[0]), 32'd0);
        chk(rv[1] == 1'b1, "R7", "master enable kept", 32'(rv[1]), 32'd1);
        reg_write(2'd3, 16'd0);
        chk(done == 1'b0, "R7", "done cleared by control write", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(bus_req == 1'b0, "R1", "reset request", 32'(bus_req), 32'd0);
        chk(done == 1'b0, "R7", "reset done", 32'(done), 32'd0);
        reg_read(2'd3, rv);
        chk(rv == 16'd0, "R12", "reset control", 32'(rv), 32'd0);
        reg_read(2'd2, rv);
        chk(rv == 16'd0, "R12", "reset count", 32'(rv), 32'd0);

        // R12 register readback
        reg_write(2'd0, 16'hABCD);
        reg_write(2'd1, 16'h1357);
        reg_write(2'd2, 16'h00A5);
        reg_write(2'd3, 16'h003C);
        reg_read(2'd0, rv);
        chk(rv == 16'hABCD, "R12", "source readback", 32'(rv), 32'hABCD);
        reg_read(2'd1, rv);
        chk(rv == 16'h1357, "R12", "destination readback", 32'(rv), 32'h1357);
        reg_read(2'd2, rv);
        chk(rv == 16'h00A5, "R12", "count readback", 32'(rv), 32'hA5);
        reg_read(2'd3, rv);
        chk(rv == 16'h003C, "R12", "control readback", 32'(rv), 32'h3C);

        // R1: one enable alone, or zero count, never requests
        setup(1, 1, 1, 16'h0100, 16'h0200, 3, 0, 0);
        reg_write(2'd3, ctrl_word(1, 0, 1, 1, 1, 1));
        repeat (16) @(negedge clk);
        chk(req_high == 0, "R1", "channel enable only", 32'(req_high), 32'd0);
        reg_write(2'd3, ctrl_word(0, 1, 0, 1, 1, 1));
        repeat (16) @(negedge clk);
        chk(req_high == 0, "R1", "master enable only", 32'(req_high), 32'd0);
        reg_write(2'd3, 16'd0);
        reg_write(2'd2, 16'd0);
        reg_write(2'd3, ctrl_word(1, 1, 1, 1, 1, 1));
        repeat (16) @(negedge clk);
        chk(req_high == 0, "R1", "zero count", 32'(req_high), 32'd0);
        reg_write(2'd3, 16'd0);

        // near-exhaustive sweep of mode, size, stepping, count, wait and grant delay
        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 2; b++)
                for (int si = 0; si < 2; si++)
                    for (int di = 0; di < 2; di++)
                        for (int ci = 0; ci < 2; ci++)
                            for (int wt = 0; wt < 3; wt += 2) begin
                                int cnt;
                                cnt = (ci == 0) ? 1 : 3;
                                run_case(w[0], b[0], si[0], di[0], cnt, wt, (cnt + wt + w) % 3);
                            end

        // R8/R10: abort in burst mode, then resume
        setup(1, 1, 1, 16'h4000, 16'hC000, 6, 1, 1);
        reg_write(2'd3, ctrl_word(1, 1, 1, 1, 1, 1));
        for (int i = 0; i < 400 && !(k == 2 && bus_rd); i++) @(negedge clk);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        repeat (20) @(negedge clk);
        chk(k == 3, "R8", "unit in flight completes, no more", 32'(k), 32'd3);
        chk(bus_req == 1'b0, "R8", "bus released after abort", 32'(bus_req), 32'd0);
        chk(req_falls == 1, "R8", "single release", 32'(req_falls), 32'd1);
        chk(done == 1'b0, "R8", "not done after abort", 32'(done), 32'd0);
        reg_read(2'd3, rv);
        chk(rv[1] == 1'b0, "R8", "master enable cleared", 32'(rv[1]), 32'd0);
        chk(rv[0] == 1'b1, "R8", "channel enable kept", 32'(rv[0]), 32'd1);
        reg_read(2'd2, rv);
        chk(rv == 16'd3, "R10", "remaining count", 32'(rv), 32'd3);
        reg_read(2'd0, rv);
        chk(rv == 16'h4006, "R10", "held source", 32'(rv), 32'h4006);
        reg_read(2'd1, rv);
        chk(rv == 16'hC006, "R10", "held destination", 32'(rv), 32'hC006);
        reg_write(2'd3, ctrl_word(1, 1, 1, 1, 1, 1));
        wait_done();
        chk(k == 6, "R10", "resumed units complete", 32'(k), 32'd6);
        chk(done == 1'b1, "R10", "done after resume", 32'(done), 32'd1);
        reg_read(2'd0, rv);
        chk(rv == 16'h400C, "R10", "source after resume", 32'(rv), 32'h400C);
        reg_write(2'd3, 16'd0);

        // R9: interrupt in cycle-steal mode does nothing
        setup(0, 1, 0, 16'h2000, 16'h3000, 4, 0, 2);
        reg_write(2'd3, ctrl_word(1, 1, 0, 0, 1, 0));
        for (int i = 0; i < 400 && k < 1; i++) @(negedge clk);
        nmi = 1'b1;
        repeat (3) @(negedge clk);
        nmi = 1'b0;
        wait_done();
        chk(k == 4, "R9", "all units complete", 32'(k), 32'd4);
        reg_read(2'd3, rv);
        chk(rv[1] == 1'b1, "R9", "master enable untouched", 32'(rv[1]), 32'd1);
        chk(done == 1'b1, "R9", "done set", 32'(done), 32'd1);
        reg_write(2'd3, 16'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule